// File: doc/BRIEF.md
# Dual Reference Selector with Holdover

This block picks one of two divided-down reference clocks to feed a downstream phase detector. Each reference is first brought into a free-running local clock domain. Its activity is then judged by a monitor that works on the already-divided signal. A reference counts as good after a run of observation windows that each hold a rising edge. It counts as lost as soon as one window passes with no edge.

Selection is manual or automatic. In manual mode the choice comes from a configuration bit or from an external select pin, and a second bit picks which of the two is used. In automatic mode the controller moves off A only when A has failed and B is good. A revert control picks the policy for coming back. With revert set, the controller returns to A as soon as A is good again. With revert clear, it stays on B and goes back to A only when B fails.

When neither reference is good the block enters holdover. The charge-pump control code then asks for either a high-impedance pump or a pump forced to mid-supply, as a configuration bit selects. Holdover ends as soon as either reference qualifies.

Top module: `refsw_top`

## Requirements
- R1: After reset the selection indicator shows A (`use_b`=0), both status flags are 0, and in automatic mode `holdover`=1 with `cp_mode`=01.
- R2: A reference status flag rises only after QUAL_WINDOWS consecutive windows of WIN_CYCLES local cycles, each holding a rising edge of that divided reference. It falls after the first window with no rising edge.
- R3: With `auto_en`=0, `use_b` equals `sel_pin` when `sel_from_pin`=1 and `sel_reg` when `sel_from_pin`=0, where 0 means A and 1 means B.
- R4: In automatic mode the controller switches from A to B only when A is not good and B is good. While A stays good it remains on A.
- R5: In automatic mode with `revert_en`=0, the controller stays on B after A becomes good again, and returns to A when B fails while A is good.
- R6: In automatic mode with `revert_en`=1, the controller on B returns to A one cycle after A's status flag is seen high.
- R7: In automatic mode, `holdover` is 1 one cycle after both status flags are seen low. On leaving holdover the controller picks A if A is good, otherwise B.
- R8: `cp_mode` is 00 outside holdover. In holdover it is 01 (high impedance) when `hold_midrail`=0 and 10 (mid-supply) when `hold_midrail`=1. The value 11 never appears.
- R9: With `auto_en`=0, `holdover` is 1 exactly when both status flags are 0, and the manual selection is kept during holdover.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running local clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_a_div | input | 1 | Divided reference A, asynchronous |
| ref_b_div | input | 1 | Divided reference B, asynchronous |
| auto_en | input | 1 | 1 = automatic selection, 0 = manual |
| sel_from_pin | input | 1 | Manual source: 1 = pin, 0 = register bit |
| sel_reg | input | 1 | Manual choice from configuration (0 = A, 1 = B) |
| sel_pin | input | 1 | Manual choice from external pin (0 = A, 1 = B) |
| revert_en | input | 1 | Automatic policy: 1 = revertive, 0 = nonrevertive |
| hold_midrail | input | 1 | Holdover pump behaviour: 1 = mid-supply, 0 = high impedance |
| use_b | output | 1 | Selected reference: 0 = A, 1 = B |
| ref_ok_a | output | 1 | Reference A qualified as good |
| ref_ok_b | output | 1 | Reference B qualified as good |
| holdover | output | 1 | Holdover active |
| cp_mode | output | 2 | Charge-pump code: 00 normal, 01 high impedance, 10 mid-supply |

## Verification
The hardest situation to reach is the nonrevertive hold. The controller must be on B while A is good again, which needs A to fail, B to take over, and A to requalify across several full windows. The stimulus runs both divided references as free-running clocks with different periods. It stops and restarts them one at a time, and waits long enough for the monitors to drop or requalify before each check. The same start and stop sequences, with the revert control flipped, then cover the revertive return. Stopping both references covers holdover and the exit choice.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

  typedef enum logic [1:0] {
    CP_NORMAL  = 2'b00,
    CP_HIGHZ   = 2'b01,
    CP_MIDRAIL = 2'b10
  } cp_mode_t;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_ON_A = 2'd1,
    ST_ON_B = 2'd2
  } sel_state_t;

  // Next qualification count: saturates at the limit, cleared on a miss.
  function automatic int unsigned qual_step(input int unsigned cur,
                                            input logic hit,
                                            input int unsigned limit);
    if (!hit)             return 0;
    else if (cur >= limit) return limit;
    else                  return cur + 1;
  endfunction

  // Pump code for a given holdover condition.
  function automatic cp_mode_t pump_code(input logic in_hold,
                                         input logic midrail);
    if (!in_hold)    return CP_NORMAL;
    else if (midrail) return CP_MIDRAIL;
    else             return CP_HIGHZ;
  endfunction

endpackage

// File: rtl/refsw_sync.sv
module refsw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  // chain[STAGES-1] is the synchronised level, chain[STAGES] its delayed copy
  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/refsw_monitor.sv
module refsw_monitor #(
  parameter int WIN_CYCLES   = 16,
  parameter int QUAL_WINDOWS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_seen,
  output logic present,
  output logic win_end
);
  import refsw_pkg::*;

  localparam int CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam int GW = $clog2(QUAL_WINDOWS + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic [CW-1:0] win_cnt;
  logic          seen_q;
  logic [GW-1:0] good_cnt;
  logic          hit;
  logic [GW-1:0] good_nxt;

  assign win_end  = (win_cnt == LAST);
  assign hit      = seen_q | edge_seen;
  assign good_nxt = GW'(qual_step(int'(good_cnt), hit, QUAL_WINDOWS));

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt  <= '0;
      seen_q   <= 1'b0;
      good_cnt <= '0;
      present  <= 1'b0;
    end else if (win_end) begin
      win_cnt  <= '0;
      seen_q   <= 1'b0;
      good_cnt <= good_nxt;
      present  <= (int'(good_nxt) >= QUAL_WINDOWS);
    end else begin
      win_cnt  <= win_cnt + 1'b1;
      seen_q   <= hit;
    end
  end
endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic ok_a,
  input  logic ok_b,
  input  logic auto_en,
  input  logic sel_from_pin,
  input  logic sel_reg,
  input  logic sel_pin,
  input  logic revert_en,
  input  logic hold_midrail,
  output logic use_b,
  output logic holdover,
  output logic [1:0] cp_mode
);
  import refsw_pkg::*;

  sel_state_t state, state_nxt;
  logic       auto_b, auto_b_nxt;
  logic       manual_b;
  cp_mode_t   code;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_ON_A: begin
        if (!ok_a) state_nxt = ok_b ? ST_ON_B : ST_HOLD;
      end
      ST_ON_B: begin
        if (!ok_b)                 state_nxt = ok_a ? ST_ON_A : ST_HOLD;
        else if (revert_en && ok_a) state_nxt = ST_ON_A;
      end
      default: begin
        if (ok_a)      state_nxt = ST_ON_A;
        else if (ok_b) state_nxt = ST_ON_B;
      end
    endcase
  end

  always_comb begin
    auto_b_nxt = auto_b;
    if (state_nxt == ST_ON_A)      auto_b_nxt = 1'b0;
    else if (state_nxt == ST_ON_B) auto_b_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_HOLD;
      auto_b <= 1'b0;
    end else begin
      state  <= state_nxt;
      auto_b <= auto_b_nxt;
    end
  end

  assign manual_b = sel_from_pin ? sel_pin : sel_reg;
  assign use_b    = auto_en ? auto_b : manual_b;
  assign holdover = auto_en ? (state == ST_HOLD) : !(ok_a || ok_b);
  assign code     = pump_code(holdover, hold_midrail);
  assign cp_mode  = code;
endmodule

// File: rtl/refsw_top.sv
module refsw_top #(
  parameter int WIN_CYCLES   = 16,
  parameter int QUAL_WINDOWS = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_a_div,
  input  logic       ref_b_div,
  input  logic       auto_en,
  input  logic       sel_from_pin,
  input  logic       sel_reg,
  input  logic       sel_pin,
  input  logic       revert_en,
  input  logic       hold_midrail,
  output logic       use_b,
  output logic       ref_ok_a,
  output logic       ref_ok_b,
  output logic       holdover,
  output logic [1:0] cp_mode
);
  localparam int NREF = 2;

  logic [NREF-1:0] ref_in;
  logic [NREF-1:0] rise_ev;
  logic [NREF-1:0] ok_vec;
  logic [NREF-1:0] win_end_ev;

  assign ref_in = {ref_b_div, ref_a_div};

  for (genvar i = 0; i < NREF; i++) begin : g_ref
    refsw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (ref_in[i]),
      .rise     (rise_ev[i])
    );
    refsw_monitor #(.WIN_CYCLES(WIN_CYCLES), .QUAL_WINDOWS(QUAL_WINDOWS)) u_mon (
      .clk       (clk),
      .rst       (rst),
      .edge_seen (rise_ev[i]),
      .present   (ok_vec[i]),
      .win_end   (win_end_ev[i])
    );
  end

  assign ref_ok_a = ok_vec[0];
  assign ref_ok_b = ok_vec[1];

  refsw_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .ok_a         (ok_vec[0]),
    .ok_b         (ok_vec[1]),
    .auto_en      (auto_en),
    .sel_from_pin (sel_from_pin),
    .sel_reg      (sel_reg),
    .sel_pin      (sel_pin),
    .revert_en    (revert_en),
    .hold_midrail (hold_midrail),
    .use_b        (use_b),
    .holdover     (holdover),
    .cp_mode      (cp_mode)
  );
endmodule

// File: rtl/refsw_checker.sv
module refsw_checker (
  input logic       clk,
  input logic       rst,
  input logic       auto_en,
  input logic       revert_en,
  input logic       use_b,
  input logic       ref_ok_a,
  input logic       ref_ok_b,
  input logic       holdover,
  input logic [1:0] cp_mode,
  input logic [1:0] win_end_ev
);
  // status flags only change on a window boundary
  p_flag_on_window_r2: assert property (@(posedge clk) disable iff (rst)
    (ref_ok_a != $past(ref_ok_a)) |-> $past(win_end_ev[0]));

  p_switch_cause_r4: assert property (@(posedge clk) disable iff (rst)
    (auto_en && $past(auto_en) && !$past(use_b) && !$past(holdover) && use_b)
      |-> ($past(!ref_ok_a) && $past(ref_ok_b)));

  p_stay_on_b_r5: assert property (@(posedge clk) disable iff (rst)
    (auto_en && $past(auto_en) && !$past(revert_en) && $past(use_b)
      && !$past(holdover) && $past(ref_ok_b)) |-> use_b);

  p_revert_to_a_r6: assert property (@(posedge clk) disable iff (rst)
    (auto_en && $past(auto_en) && $past(revert_en) && $past(ref_ok_a))
      |-> !use_b && !holdover);

  p_enter_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (auto_en && $past(auto_en) && $past(!ref_ok_a && !ref_ok_b)) |-> holdover);

  p_pump_code_r8: assert property (@(posedge clk) disable iff (rst)
    (cp_mode != 2'b11) && (holdover == (cp_mode != 2'b00)));

  p_manual_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!auto_en && (ref_ok_a || ref_ok_b)) |-> !holdover);
endmodule

bind refsw_top refsw_checker u_refsw_checker (
  .clk        (clk),
  .rst        (rst),
  .auto_en    (auto_en),
  .revert_en  (revert_en),
  .use_b      (use_b),
  .ref_ok_a   (ref_ok_a),
  .ref_ok_b   (ref_ok_b),
  .holdover   (holdover),
  .cp_mode    (cp_mode),
  .win_end_ev (win_end_ev)
);

// File: tb/refsw_top_bench.sv
`timescale 1ns/1ps
module refsw_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_a = 1'b0, ref_b = 1'b0;
  logic run_a = 1'b0, run_b = 1'b0;
  logic auto_en = 1'b1, sel_from_pin = 1'b0, sel_reg = 1'b0, sel_pin = 1'b0;
  logic revert_en = 1'b0, hold_midrail = 1'b0;
  logic use_b, ok_a, ok_b, holdover;
  logic [1:0] cp_mode;
  int checks = 0, fails = 0;
  bit done = 0;

  // window 16, 3 windows to qualify: rise needs < 4 windows + sync, loss < 2 windows
  localparam int T_QUAL = 100;
  localparam int T_LOSS = 60;

  refsw_top u_refsw_top (
    .clk(clk), .rst(rst), .ref_a_div(ref_a), .ref_b_div(ref_b),
    .auto_en(auto_en), .sel_from_pin(sel_from_pin), .sel_reg(sel_reg),
    .sel_pin(sel_pin), .revert_en(revert_en), .hold_midrail(hold_midrail),
    .use_b(use_b), .ref_ok_a(ok_a), .ref_ok_b(ok_b),
    .holdover(holdover), .cp_mode(cp_mode)
  );

  initial forever #4 clk = ~clk;
  initial forever begin #20; if (run_a) ref_a = ~ref_a; end
  initial forever begin #28; if (run_b) ref_b = ~ref_b; end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    wait_clks(3);
    chk("R1", "use_b", use_b, 0);
    chk("R1", "ok_a", ok_a, 0);
    chk("R1", "ok_b", ok_b, 0);
    chk("R1", "holdover", holdover, 1);
    chk("R1", "cp_mode", cp_mode, 2'b01);
  endtask

  task automatic t_qualify_a;
    run_a = 1;
    wait_clks(30);
    chk("R2", "ok_a early", ok_a, 0);
    wait_clks(T_QUAL);
    chk("R2", "ok_a qualified", ok_a, 1);
    chk("R7", "holdover exit to A", {holdover, use_b}, 2'b00);
    chk("R8", "cp_mode normal", cp_mode, 2'b00);
  endtask

  task automatic t_nonrevert;
    revert_en = 0;
    run_b = 1;
    wait_clks(T_QUAL);
    chk("R2", "ok_b qualified", ok_b, 1);
    chk("R4", "stay on good A", use_b, 0);
    run_a = 0;
    wait_clks(T_LOSS);
    chk("R2", "ok_a lost", ok_a, 0);
    chk("R4", "switch to B", {holdover, use_b}, 2'b01);
    run_a = 1;
    wait_clks(T_QUAL);
    chk("R5", "A back, still B", {ok_a, use_b}, 2'b11);
    run_b = 0;
    wait_clks(T_LOSS);
    chk("R5", "B lost, back to A", {holdover, use_b}, 2'b00);
  endtask

  task automatic t_revert;
    revert_en = 1;
    run_b = 1;
    wait_clks(T_QUAL);
    run_a = 0;
    wait_clks(T_LOSS);
    chk("R6", "on B while A lost", use_b, 1);
    run_a = 1;
    wait_clks(T_QUAL);
    chk("R6", "reverted to A", {ok_b, use_b}, 2'b10);
  endtask

  task automatic t_holdover;
    revert_en = 0;
    hold_midrail = 0;
    run_a = 0; run_b = 0;
    wait_clks(T_LOSS);
    chk("R7", "holdover", holdover, 1);
    chk("R8", "cp high impedance", cp_mode, 2'b01);
    hold_midrail = 1;
    wait_clks(1);
    chk("R8", "cp mid-supply", cp_mode, 2'b10);
    run_b = 1;
    wait_clks(T_QUAL);
    chk("R7", "exit to B", {holdover, use_b}, 2'b01);
    chk("R8", "cp normal after exit", cp_mode, 2'b00);
  endtask

  task automatic t_manual;
    auto_en = 0; sel_from_pin = 0; sel_reg = 0; sel_pin = 1;
    wait_clks(1);
    chk("R3", "reg selects A", use_b, 0);
    sel_reg = 1;
    wait_clks(1);
    chk("R3", "reg selects B", use_b, 1);
    sel_from_pin = 1; sel_pin = 0;
    wait_clks(1);
    chk("R3", "pin selects A over reg", use_b, 0);
    sel_pin = 1;
    run_b = 0;
    wait_clks(T_LOSS);
    chk("R9", "manual holdover", holdover, 1);
    chk("R9", "manual choice kept", use_b, 1);
    run_a = 1;
    wait_clks(T_QUAL);
    chk("R9", "manual holdover ends", {holdover, use_b}, 2'b01);
  endtask

  initial begin
    wait_clks(4);
    rst = 0;
    t_reset();
    t_qualify_a();
    t_nonrevert();
    t_revert();
    t_holdover();
    t_manual();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule